// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block collects sixteen interrupt sources into one request line and answers a shared, active-low acknowledge with an 8-bit vector. Channels 7..0 come from eight general-purpose pins. Each pin has a selectable active edge and a direction bit. Channels 15..8 come from eight internal single-cycle pulse inputs. Every channel carries four bits of state: an enable, a pending latch, a mask and an in-service latch. Priority is fixed: channel 15 is the highest and channel 0 the lowest. Software can reorder priority only by masking channels.

Several controllers can share one acknowledge line. On the first clock edge that sees the acknowledge low, each controller freezes its choice of winner. Priority then ripples combinationally through a priority-in / priority-out pair. The first controller that holds an acknowledgeable interrupt and sees priority-in low answers: it drives its vector and a transfer-acknowledge strobe and keeps priority-out high. A controller with nothing to answer drives priority-out low to the next device. A small synchronous write port and a combinational read port give access to the registers.

Top module: `vic_chain`

## Requirements
- R1: After reset every register reads 0, `irq_n`, `xfer_ack_n` and `pri_out_n` are 1, and `vec_out` is 0.
- R2: An answered vector is {vector-base bits 7:4, 4-bit winning channel}. The winner is the highest-numbered pending, unmasked channel at the clock edge where `ack_n` is first seen low.
- R3: `xfer_ack_n` is low and `vec_out` is non-zero only after `ack_n` has been low on a clock edge, while `ack_n` and `pri_in_n` are still low and an acknowledgeable interrupt was captured. Otherwise `xfer_ack_n` is 1 and `vec_out` is 0.
- R4: `pri_out_n` is low only while the acknowledge is active, `pri_in_n` is low and no interrupt was captured. It stays high while the block answers.
- R5: On the first cycle of an answer, the winner's pending bit clears and its in-service bit sets. This happens exactly once per acknowledge.
- R6: `irq_n` is low exactly when some pending, unmasked channel is higher than the highest in-service channel. A mask bit of 1 blocks the request but does not stop pending from latching.
- R7: A channel whose enable bit is 0 never sets pending. Writing an enable bit to 0 also clears that channel's pending bit.
- R8: Edge register bit i = 1 makes pin i trigger on a rising edge; 0 makes it trigger on a falling edge. Direction bit i = 1 marks pin i as an output, and then the pin raises no interrupt. Changing either bit while the pin is stable creates no event.
- R9: A one-cycle high on `int_pulse[j]` sets pending of channel 8+j when that channel is enabled.
- R10: A write to a pending or in-service register clears the bits written as 0 and leaves the bits written as 1 unchanged.
- R11: While the acknowledge is held, events that arrive after the capture edge latch into pending but do not change the vector being driven.
- R12: Register map. Addresses 0/1 are enable, 2/3 pending, 4/5 mask and 6/7 in-service; the even address holds channels 15..8 and the odd address holds channels 7..0. Address 8 is the edge select, 9 the direction and 10 the vector base (bits 7:4 kept, bits 3:0 read 0). Address 11 reads the pins. A new event sets pending in the same cycle that a write or an answer clears it; the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gp_pin | input | 8 | General-purpose pins, sources of channels 7..0 |
| int_pulse | input | 8 | Internal event pulses, sources of channels 15..8 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| ack_n | input | 1 | Shared interrupt acknowledge, active low |
| pri_in_n | input | 1 | Chain priority in, active low |
| pri_out_n | output | 1 | Chain priority out, active low |
| xfer_ack_n | output | 1 | Transfer acknowledge, active low |
| vec_out | output | 8 | Interrupt vector, 0 when not answering |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that `int_pulse` and the pin inputs are synchronous to `clk`, and that `pri_in_n` settles within the same cycle as the acknowledge. They also assume that no register write lands in the cycle an answer commits. The stimulus meets these assumptions in three ways. It drives every input at the falling clock edge. It performs acknowledges as atomic sequences, with register writes and pin changes only in between. It waits for the pin synchronizer to settle before checking.

// File: rtl/vic_pkg.sv
package vic_pkg;
   localparam int VIC_NCH  = 16;
   localparam int VIC_BANK = 8;
   localparam int VIC_AW   = 4;
   localparam int VIC_CHW  = $clog2(VIC_NCH);

   localparam logic [VIC_AW-1:0] A_EDGE  = 4'd8;
   localparam logic [VIC_AW-1:0] A_DIR   = 4'd9;
   localparam logic [VIC_AW-1:0] A_VBASE = 4'd10;
   localparam logic [VIC_AW-1:0] A_PINS  = 4'd11;
endpackage

// File: rtl/vic_pin_edge.sv
module vic_pin_edge #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin,
   input  logic [W-1:0] rise_sel,
   input  logic [W-1:0] is_out,
   output logic [W-1:0] evt
);
   logic [W-1:0] s;
   logic [W-1:0] prev;

   generate
      if (STAGES > 3) begin : g_bad
         $error("vic_pin_edge: STAGES must be 0..3");
      end
      if (STAGES == 0) begin : g_direct
         assign s = pin;
      end else begin : g_sync
         logic [STAGES-1:0][W-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else begin
               chain[0] <= pin;
               for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
            end
         end
         assign s = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= s;
   end

   assign evt = ~is_out & ((rise_sel & s & ~prev) | (~rise_sel & ~s & prev));
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
   parameter int N  = 16,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/vic_bank.sv
module vic_bank
   import vic_pkg::*;
#(
   parameter int NCH = VIC_NCH,
   parameter int BW  = VIC_BANK,
   localparam int NB = NCH / BW,
   localparam int CW = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [VIC_AW-1:0] waddr,
   input  logic [BW-1:0]     wdata,
   input  logic [NCH-1:0]    set_evt,
   input  logic              commit,
   input  logic [CW-1:0]     commit_ch,
   output logic [NCH-1:0]    en_o,
   output logic [NCH-1:0]    pend_o,
   output logic [NCH-1:0]    mask_o,
   output logic [NCH-1:0]    svc_o
);
   logic [NCH-1:0] en_q, pend_q, mask_q, svc_q;
   logic [NCH-1:0] en_wr, pend_wr, mask_wr, svc_wr;
   logic [NCH-1:0] wvec, commit_bits, en_n;

   generate
      if (NCH % BW != 0) begin : g_bad
         $error("vic_bank: NCH must be a multiple of BW");
      end
      for (genvar b = 0; b < NB; b++) begin : g_half
         localparam int OFS = NB - 1 - b;
         assign en_wr[b*BW +: BW]   = {BW{wr && waddr == VIC_AW'(0*NB + OFS)}};
         assign pend_wr[b*BW +: BW] = {BW{wr && waddr == VIC_AW'(1*NB + OFS)}};
         assign mask_wr[b*BW +: BW] = {BW{wr && waddr == VIC_AW'(2*NB + OFS)}};
         assign svc_wr[b*BW +: BW]  = {BW{wr && waddr == VIC_AW'(3*NB + OFS)}};
      end
   endgenerate

   assign wvec        = {NB{wdata}};
   assign commit_bits = commit ? (NCH'(1) << commit_ch) : '0;
   assign en_n        = (en_q & ~en_wr) | (wvec & en_wr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         pend_q <= '0;
         mask_q <= '0;
         svc_q  <= '0;
      end else begin
         en_q   <= en_n;
         pend_q <= ((pend_q & ~(pend_wr & ~wvec) & ~commit_bits) | set_evt) & en_n;
         mask_q <= (mask_q & ~mask_wr) | (wvec & mask_wr);
         svc_q  <= (svc_q & ~(svc_wr & ~wvec)) | commit_bits;
      end
   end

   assign en_o   = en_q;
   assign pend_o = pend_q;
   assign mask_o = mask_q;
   assign svc_o  = svc_q;

   AST_COMMIT_SETS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> ((svc_q & $past(commit_bits)) == $past(commit_bits))); // R5

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_chk
         AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_q[i]) |-> en_q[i]); // R7
      end
   endgenerate
endmodule

// File: rtl/vic_chain.sv
module vic_chain
   import vic_pkg::*;
#(
   parameter int NGP         = VIC_BANK,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NGP-1:0]    gp_pin,
   input  logic [NGP-1:0]    int_pulse,
   input  logic              reg_wr,
   input  logic [VIC_AW-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              ack_n,
   input  logic              pri_in_n,
   output logic              pri_out_n,
   output logic              xfer_ack_n,
   output logic [7:0]        vec_out,
   output logic              irq_n
);
   generate
      if (NGP != VIC_BANK || VIC_NCH != 2 * VIC_BANK) begin : g_bad
         $error("vic_chain: needs two 8-channel banks");
      end
   endgenerate

   logic [NGP-1:0]     edge_q, dir_q, gp_evt;
   logic [3:0]         base_q;
   logic [VIC_NCH-1:0] en, pend, mask, svc;
   logic               req_any, svc_any, ackable;
   logic [VIC_CHW-1:0] req_ch, svc_ch, win_q;
   logic               active_q, hit_q, done_q;
   logic               respond, commit;

   vic_pin_edge #(.W(NGP), .STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(gp_pin),
      .rise_sel(edge_q), .is_out(dir_q), .evt(gp_evt));

   vic_bank #(.NCH(VIC_NCH), .BW(VIC_BANK)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .waddr(reg_addr),
      .wdata(reg_wdata), .set_evt({int_pulse, gp_evt}),
      .commit(commit), .commit_ch(win_q),
      .en_o(en), .pend_o(pend), .mask_o(mask), .svc_o(svc));

   vic_prio #(.N(VIC_NCH)) u_req (.req(pend & ~mask), .any(req_any), .idx(req_ch));
   vic_prio #(.N(VIC_NCH)) u_svc (.req(svc), .any(svc_any), .idx(svc_ch));

   assign ackable = req_any && (!svc_any || req_ch > svc_ch);
   assign irq_n   = ~ackable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_q <= '0;
         dir_q  <= '0;
         base_q <= '0;
      end else if (reg_wr) begin
         if (reg_addr == A_EDGE)  edge_q <= reg_wdata;
         if (reg_addr == A_DIR)   dir_q  <= reg_wdata;
         if (reg_addr == A_VBASE) base_q <= reg_wdata[7:4];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         hit_q    <= 1'b0;
         win_q    <= '0;
         done_q   <= 1'b0;
      end else begin
         active_q <= ~ack_n;
         done_q   <= ~ack_n & (done_q | commit);
         if (~ack_n && !active_q) begin
            hit_q <= ackable;
            win_q <= req_ch;
         end
      end
   end

   assign respond    = active_q & ~ack_n & ~pri_in_n & hit_q;
   assign commit     = respond & ~done_q;
   assign pri_out_n  = ~(active_q & ~ack_n & ~pri_in_n & ~hit_q);
   assign xfer_ack_n = ~respond;
   assign vec_out    = respond ? {base_q, win_q} : 8'h00;

   always_comb begin
      case (reg_addr)
         4'd0:    reg_rdata = en[15:8];
         4'd1:    reg_rdata = en[7:0];
         4'd2:    reg_rdata = pend[15:8];
         4'd3:    reg_rdata = pend[7:0];
         4'd4:    reg_rdata = mask[15:8];
         4'd5:    reg_rdata = mask[7:0];
         4'd6:    reg_rdata = svc[15:8];
         4'd7:    reg_rdata = svc[7:0];
         A_EDGE:  reg_rdata = edge_q;
         A_DIR:   reg_rdata = dir_q;
         A_VBASE: reg_rdata = {base_q, 4'h0};
         A_PINS:  reg_rdata = gp_pin;
         default: reg_rdata = 8'h00;
      endcase
   end

   AST_ANSWER_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_ack_n |-> (!ack_n && !pri_in_n)); // R3
   AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ack_n |-> (vec_out == 8'h00)); // R3
   AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_ack_n |-> (vec_out[7:4] == base_q)); // R2
   AST_NO_PASS_WHEN_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_ack_n |-> pri_out_n); // R4
   AST_PASS_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
      !pri_out_n |-> (!pri_in_n && !ack_n)); // R4
   AST_VEC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_ack_n && $past(!xfer_ack_n)) |-> $stable(vec_out)); // R11
   AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit); // R5
   AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> ((pend & ~mask) != '0)); // R6
endmodule

// File: tb/sim_vic_chain.sv
`timescale 1ns/100ps
module sim_vic_chain;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] gp_pin = '0, int_pulse = '0;
   logic       reg_wr = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0, reg_rdata, vec_out;
   logic       ack_n = 1'b1, pri_in_n = 1'b1;
   logic       pri_out_n, xfer_ack_n, irq_n;

   int n_chk = 0, n_err = 0;
   logic [15:0] m_en = '0, m_pend = '0, m_mask = '0, m_svc = '0;
   logic [7:0]  m_edge = '0, m_dir = '0, m_pin = '0;
   logic [3:0]  m_base = '0;

   always #4 clk = ~clk;

   vic_chain u0 (.clk(clk), .rst_n(rst_n), .gp_pin(gp_pin), .int_pulse(int_pulse),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ack_n(ack_n), .pri_in_n(pri_in_n), .pri_out_n(pri_out_n),
      .xfer_ack_n(xfer_ack_n), .vec_out(vec_out), .irq_n(irq_n));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [4:0] top_of(logic [15:0] v);
      logic [4:0] r = '0;
      for (int i = 0; i < 16; i++) if (v[i]) r = {1'b1, 4'(i)};
      return r;
   endfunction

   function automatic logic [4:0] m_winner();
      logic [4:0] p = top_of(m_pend & ~m_mask);
      logic [4:0] s = top_of(m_svc);
      return (p[4] && (!s[4] || p[3:0] > s[3:0])) ? p : 5'd0;
   endfunction

   task automatic wr_reg(logic [3:0] a, logic [7:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
      case (a)
         4'd0: begin m_en[15:8] = d; m_pend &= m_en; end
         4'd1: begin m_en[7:0]  = d; m_pend &= m_en; end
         4'd2: m_pend[15:8] &= d;
         4'd3: m_pend[7:0]  &= d;
         4'd4: m_mask[15:8] = d;
         4'd5: m_mask[7:0]  = d;
         4'd6: m_svc[15:8] &= d;
         4'd7: m_svc[7:0]  &= d;
         4'd8: m_edge = d;
         4'd9: m_dir = d;
         4'd10: m_base = d[7:4];
         default: ;
      endcase
   endtask

   task automatic pulse(int j);
      @(negedge clk); int_pulse[j] = 1'b1;
      @(negedge clk); int_pulse = '0;
      if (m_en[8+j]) m_pend[8+j] = 1'b1;
   endtask

   task automatic set_pins(logic [7:0] v);
      @(negedge clk); gp_pin = v;
      for (int i = 0; i < 8; i++) begin
         if (!m_dir[i] && m_en[i] && v[i] != m_pin[i] && v[i] == m_edge[i]) m_pend[i] = 1'b1;
      end
      m_pin = v;
      repeat (5) @(negedge clk);
   endtask

   task automatic compare_all(string tag);
      for (int a = 0; a < 8; a++) begin
         reg_addr = 4'(a); #0.5;
         case (a)
            0: chk({tag, " R12 en hi"},   reg_rdata, m_en[15:8]);
            1: chk({tag, " R12 en lo"},   reg_rdata, m_en[7:0]);
            2: chk({tag, " R7 pend hi"},  reg_rdata, m_pend[15:8]);
            3: chk({tag, " R7 pend lo"},  reg_rdata, m_pend[7:0]);
            4: chk({tag, " R12 mask hi"}, reg_rdata, m_mask[15:8]);
            5: chk({tag, " R12 mask lo"}, reg_rdata, m_mask[7:0]);
            6: chk({tag, " R5 svc hi"},   reg_rdata, m_svc[15:8]);
            default: chk({tag, " R5 svc lo"}, reg_rdata, m_svc[7:0]);
         endcase
      end
      chk({tag, " R6 irq_n"}, irq_n, !m_winner()[4]);
   endtask

   // frz >= 0 pulses int_pulse[frz] in the commit cycle (R11)
   task automatic ack_seq(logic chain_low, int frz, string tag);
      logic [4:0] w = m_winner();
      logic ans = chain_low && w[4];
      logic [7:0] ev = ans ? {m_base, w[3:0]} : 8'h00;
      @(negedge clk); ack_n = 1'b0; pri_in_n = !chain_low;
      @(negedge clk);
      chk({tag, " R3 xfer_ack_n"}, xfer_ack_n, !ans);
      chk({tag, " R2 vector"}, vec_out, ev);
      chk({tag, " R4 pri_out_n"}, pri_out_n, !(chain_low && !w[4]));
      if (frz >= 0) int_pulse[frz] = 1'b1;
      @(negedge clk);
      int_pulse = '0;
      chk({tag, " R11 vector held"}, vec_out, ev);
      ack_n = 1'b1; pri_in_n = 1'b1;
      @(negedge clk);
      chk({tag, " R3 released"}, {xfer_ack_n, pri_out_n, vec_out}, {2'b11, 8'h00});
      if (ans) begin m_pend[w[3:0]] = 1'b0; m_svc[w[3:0]] = 1'b1; end
      if (frz >= 0 && m_en[8+frz]) m_pend[8+frz] = 1'b1;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'h1F3A_5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 11; a++) begin
         reg_addr = 4'(a); #0.5; chk("R1 reset reg", reg_rdata, 8'h00);
      end
      chk("R1 reset outs", {irq_n, xfer_ack_n, pri_out_n, vec_out}, {3'b111, 8'h00});
      // R12 vector base keeps upper nibble only
      wr_reg(4'd10, 8'hA5);
      reg_addr = 4'd10; #0.5; chk("R12 vbase", reg_rdata, 8'hA0);
      // R9 internal pulse, R6 request
      wr_reg(4'd0, 8'hFF);
      pulse(2);
      compare_all("R9 pulse ch10");
      ack_seq(1'b1, -1, "R2 first ack");
      compare_all("R5 after ack");
      // R8 rising edge, R6 in-service blocks lower
      wr_reg(4'd1, 8'hFF);
      wr_reg(4'd8, 8'hFF);
      set_pins(8'h20);
      compare_all("R6 blocked by svc");
      pulse(6);
      compare_all("R6 higher preempts");
      ack_seq(1'b0, -1, "R4 not our turn");
      ack_seq(1'b1, -1, "R2 ch14");
      // R10 write-0 clears in-service
      wr_reg(4'd6, 8'hBF);
      compare_all("R10 svc partial");
      wr_reg(4'd6, 8'h00);
      compare_all("R10 svc cleared");
      // R6 mask holds request but keeps pending
      wr_reg(4'd5, 8'h20);
      compare_all("R6 masked");
      wr_reg(4'd5, 8'h00);
      // R7 disable clears pending and blocks new events
      wr_reg(4'd1, 8'h00);
      set_pins(8'h00);
      set_pins(8'h20);
      compare_all("R7 disabled");
      // R8 falling edge and output pin
      wr_reg(4'd1, 8'hFF);
      wr_reg(4'd8, 8'h00);
      wr_reg(4'd9, 8'h10);
      set_pins(8'h32);
      compare_all("R8 rise ignored");
      set_pins(8'h00);
      compare_all("R8 fall and out pin");
      // R4 empty controller passes priority
      wr_reg(4'd3, 8'h00);
      wr_reg(4'd2, 8'h00);
      ack_seq(1'b1, -1, "R4 pass down");
      // R11 freeze: ch3 captured, ch12 arrives mid-acknowledge
      wr_reg(4'd8, 8'hFF);
      set_pins(8'h08);
      ack_seq(1'b1, 4, "R11 freeze");
      compare_all("R11 after freeze");
      // constrained random
      for (int n = 0; n < 400; n++) begin
         int op = $urandom_range(0, 5);
         case (op)
            0: wr_reg(4'($urandom_range(0, 10)), 8'($urandom));
            1: pulse($urandom_range(0, 7));
            2: set_pins(8'($urandom));
            3: ack_seq($urandom_range(0, 3) != 0, $urandom_range(0, 1) ? $urandom_range(0, 7) : -1, "R2 rand ack");
            4: wr_reg(4'($urandom_range(6, 7)), 8'($urandom));
            default: wr_reg(4'($urandom_range(0, 1)), 8'($urandom) | 8'($urandom));
         endcase
         compare_all("R12 rand");
      end
      finish_run();
   end
endmodule